// File: doc/BRIEF.md
# Programmable Edge Delay Cell

This block shifts the timing of a logic pulse by a number of fast clock cycles chosen on a select bus. The delay line is a shift register clocked by an oversampling clock. A multiplexer takes one point of that line as the delayed copy. A gating stage then combines the delayed copy with the undelayed input. Depending on a build-time mode, the gating stage delays only the rising edge, only the falling edge, or both edges.

A typical use is in the timing loop of a gate driver, where a controller adjusts the select word from one switching cycle to the next. The select word is captured only while the pulse is idle, so a new setting takes effect on the next pulse and cannot cut into the current one. The output itself is combinational from the input and the chosen tap. A zero setting therefore passes the input with no added latency.

Top module: `edge_delay_cell`

## Requirements
- R1: With an applied setting k and the symmetric mode, the output equals the input as it was k clock cycles earlier, and the pulse width is preserved.
- R2: An applied setting of 0 gives an output equal to the input in the same cycle, with no register in the path, in every mode.
- R3: In mode EDGE_RISE (encoding 0), the output is the input AND the delayed tap. A rising edge is delayed by k cycles, a falling edge reaches the output at once, and a pulse of k cycles or fewer produces no output.
- R4: In mode EDGE_FALL (encoding 1), the output is the input OR the delayed tap. A rising edge passes at once, and a falling edge is held for k extra cycles.
- R5: In mode EDGE_BOTH (encoding 2), the output is the delayed tap alone, so both edges move by k cycles.
- R6: A select word of all ones gives the largest delay, 2^SEL_W - 1 cycles.
- R7: The select word is copied into the applied setting on a clock edge only when the input and the output are both low. A change while the input or output is high is ignored until both have returned low.
- R8: Reset is asynchronous and active low. It clears every stage of the line and sets the applied setting to 0, so the output is low while the input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock; one cycle per delay element |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Pulse to be shaped |
| dly_sel | input | SEL_W | Requested delay in clock cycles |
| pulse_out | output | 1 | Shaped pulse |

## Verification
The embedded assertions check four things on every clock edge. The applied setting holds whenever the input or output is high. A zero setting makes the output follow the input. The chosen mode's gating keeps the output low with a low input (rising-edge mode) or high with a high input (falling-edge mode). Reset forces the output low. The exact delay in cycles, the preserved width, the suppression of short pulses and the deferred take-up of a select change are shown only by the bench. It sweeps every setting against many pulse widths in all three modes and compares the result with a cycle model of the input history.

// File: rtl/edc_pkg.sv
`timescale 1ns/1ps
package edc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_mode_e;

  // A new delay setting may be taken only when the cell is idle.
  function automatic logic sel_loadable(logic din, logic dout);
    return !din && !dout;
  endfunction

  // Combine the undelayed input with the selected tap for a given mode.
  function automatic logic edge_combine(edge_mode_e mode, logic din, logic tap);
    case (mode)
      EDGE_RISE: return din & tap;
      EDGE_FALL: return din | tap;
      default:   return tap;
    endcase
  endfunction

endpackage

// File: rtl/edc_tap_chain.sv
`timescale 1ns/1ps
module edc_tap_chain #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  logic [DEPTH-1:1] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[1] <= din;
      for (int k = 2; k < DEPTH; k++) begin
        stage_q[k] <= stage_q[k-1];
      end
    end
  end

  // Tap 0 is the bypass; tap k is the input k cycles ago.
  assign taps = {stage_q, din};

endmodule

// File: rtl/edc_tap_mux.sv
`timescale 1ns/1ps
module edc_tap_mux #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] taps,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_o
);

  assign tap_o = taps[sel];

endmodule

// File: rtl/edc_edge_gate.sv
`timescale 1ns/1ps
module edc_edge_gate
  import edc_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE
) (
  input  logic din,
  input  logic tap,
  output logic dout
);

  generate
    if (MODE == EDGE_RISE) begin : g_rise
      assign dout = din & tap;
    end else if (MODE == EDGE_FALL) begin : g_fall
      assign dout = din | tap;
    end else begin : g_both
      assign dout = tap;
    end
  endgenerate

endmodule

// File: rtl/edge_delay_cell.sv
`timescale 1ns/1ps
module edge_delay_cell
  import edc_pkg::*;
#(
  parameter int         SEL_W = 4,
  parameter edge_mode_e MODE  = EDGE_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             pulse_out
);

  localparam int DEPTH = 1 << SEL_W;

  logic [SEL_W-1:0] sel_q;
  logic             sel_load;
  logic [DEPTH-1:0] line_taps;
  logic             tap_sel;

  // Applied setting: refreshed only while the cell is idle (R7).
  assign sel_load = sel_loadable(pulse_in, pulse_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (sel_load) sel_q <= dly_sel;
  end

  edc_tap_chain #(.DEPTH(DEPTH)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pulse_in),
    .taps  (line_taps)
  );

  edc_tap_mux #(.SEL_W(SEL_W)) u_mux (
    .taps  (line_taps),
    .sel   (sel_q),
    .tap_o (tap_sel)
  );

  edc_edge_gate #(.MODE(MODE)) u_gate (
    .din  (pulse_in),
    .tap  (tap_sel),
    .dout (pulse_out)
  );

  // ---------------- assertions ----------------
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_in || pulse_out) |=> $stable(sel_q));

  p_zero_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> (pulse_out == pulse_in));

  p_reset_low_r8: assert property (@(posedge clk)
    (!rst_n && !pulse_in) |-> !pulse_out);

  generate
    if (MODE == EDGE_RISE) begin : g_chk_rise
      p_rise_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_in |-> !pulse_out);
    end else if (MODE == EDGE_FALL) begin : g_chk_fall
      p_fall_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_in |-> pulse_out);
    end
  endgenerate

endmodule

// File: tb/edge_delay_cell_bench.sv
`timescale 1ns/1ps
module edge_delay_cell_bench;
  import edc_pkg::*;

  localparam int SEL_W = 4;
  localparam int DEPTH = 1 << SEL_W;
  localparam int HIST  = 16384;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_in = 1'b0;
  logic [SEL_W-1:0] dly_sel = '0;
  logic             out_rise, out_fall, out_both;

  always #2 clk = ~clk;

  edge_delay_cell #(.SEL_W(SEL_W), .MODE(EDGE_RISE)) u_edge_delay_cell (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .dly_sel(dly_sel), .pulse_out(out_rise));
  edge_delay_cell #(.SEL_W(SEL_W), .MODE(EDGE_FALL)) u_edge_delay_cell_fall (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .dly_sel(dly_sel), .pulse_out(out_fall));
  edge_delay_cell #(.SEL_W(SEL_W), .MODE(EDGE_BOTH)) u_edge_delay_cell_both (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .dly_sel(dly_sel), .pulse_out(out_both));

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  logic hist [HIST];
  int   cyc = 0;
  int   base = 0;
  int   eff [3];
  logic exp_prev [3];
  logic prev_in = 0;
  int   prev_sel = 0;

  function automatic logic model_out(int m, logic din, logic tap);
    if (m == 0) return din & tap;
    if (m == 1) return din | tap;
    return tap;
  endfunction

  function automatic logic get_out(int m);
    if (m == 0) return out_rise;
    if (m == 1) return out_fall;
    return out_both;
  endfunction

  task automatic check(string req, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %b expected %b", req, cyc, got, exp);
    end
  endtask

  function automatic string sel_tag(int s);
    if (s == 0) return "R2";
    if (s == DEPTH - 1) return "R6";
    return "R1";
  endfunction

  // One clock cycle: update the model's applied setting, drive, then compare.
  task automatic step(logic in_v, int sel_v, string extra);
    @(negedge clk);
    for (int m = 0; m < 3; m++)
      if (!prev_in && !exp_prev[m]) eff[m] = prev_sel;   // R7 load rule
    pulse_in = in_v;
    dly_sel  = sel_v[SEL_W-1:0];
    hist[cyc] = in_v;
    #1;
    for (int m = 0; m < 3; m++) begin
      logic tapv, e;
      string mt;
      tapv = (cyc - eff[m] >= base) ? hist[cyc - eff[m]] : 1'b0;
      e = model_out(m, in_v, tapv);
      mt = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
      check($sformatf("%s/%s%s", mt, sel_tag(eff[m]), extra), get_out(m), e);
      exp_prev[m] = e;
    end
    prev_in  = in_v;
    prev_sel = sel_v;
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    pulse_in = 0;
    dly_sel  = '0;
    rst_n    = 0;
    #1;
    check("R8 rise", out_rise, 1'b0);
    check("R8 fall", out_fall, 1'b0);
    check("R8 both", out_both, 1'b0);
    @(negedge clk);
    #1;
    check("R8 hold", out_fall | out_rise | out_both, 1'b0);
    rst_n = 1;
    base = cyc;
    prev_in = 0;
    prev_sel = 0;
    for (int m = 0; m < 3; m++) begin
      eff[m] = 0;
      exp_prev[m] = 0;
    end
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      eff[m] = 0;
      exp_prev[m] = 0;
    end
    #1;
    check("R8 initial", out_rise | out_fall | out_both, 1'b0);
    do_reset();

    // Sweep every setting against pulse widths 1..18 (R1-family, R3, R4, R5, R6).
    for (int s = 0; s < DEPTH; s++) begin
      for (int w = 1; w <= 18; w++) begin
        for (int g = 0; g < 20; g++) step(1'b0, s, "");
        for (int h = 0; h < w; h++) step(1'b1, s, "");
      end
    end
    for (int g = 0; g < 20; g++) step(1'b0, 3, "");

    // R7: select change in the middle of a pulse must not apply to it.
    for (int g = 0; g < 20; g++) step(1'b0, 3, " R7");
    for (int h = 0; h < 10; h++) step(1'b1, (h < 4) ? 3 : 12, " R7");
    for (int g = 0; g < 20; g++) step(1'b0, 12, " R7");
    for (int h = 0; h < 14; h++) step(1'b1, 12, " R7");
    for (int g = 0; g < 20; g++) step(1'b0, 1, " R7");

    // R8: reset in the middle of a delayed tail clears it.
    for (int g = 0; g < 20; g++) step(1'b0, 15, " R8");
    for (int h = 0; h < 5; h++) step(1'b1, 15, " R8");
    step(1'b0, 15, " R8");
    do_reset();
    for (int g = 0; g < 20; g++) step(1'b0, 5, " R8");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule